// File: doc/BRIEF.md
# SMBus Register Access Bridge

This block sits behind an SMBus slave that has already decoded bits, START/STOP and byte framing. It collects the parameter bytes of one or more SMBus write transactions into a single internal access request. That request targets either configuration space or memory space. The first byte of every write is a header carrying three flags: End, space and command. The data bytes fill a parameter slot pointer that carries over from one write to the next. As a result, byte, word and block writes can be mixed freely to build one request.

A write whose header has End set triggers the access. The block then issues one read or write on a simple request/acknowledge internal bus. It asserts a clock-stretch request until that bus answers, and only then acknowledges the final write. An internal error turns that acknowledgement into a NACK. If a write carries a command that differs from the earlier writes of the same sequence, the whole sequence is discarded and the write is NACKed. Read data is kept in a holding register, and a following SMBus read fetches it one byte at a time.

Top module: `smbus_reg_bridge`

## Requirements
- R1: A synchronous active-high reset clears all parameter slots, the slot pointer, the sequence command, the stretch output, the pending internal request and the read holding register. After reset, `rd_byte` reads 0 and `smb_ack_vld`, `smb_nack`, `smb_stretch` and `ib_req` are all 0.
- R2: A write whose header has End (bit 7) clear is acknowledged the cycle after `wr_end` (`smb_ack_vld`=1, `smb_nack`=0). It starts no internal request.
- R3: For a configuration access (header bit 6 = 0) the slots are used as follows: slot 0 is the bus number, slot 1 is device/function, slot 2 is register low byte and slot 3 is register high byte. `ib_cfg`=1 and `ib_addr` = {zeros, slot3[3:0], slot2}. Slot 0, slot 1 and slot3[7:4] have no effect on the address.
- R4: For a memory access (header bit 6 = 1) the slots are used as follows: slot 0 is ignored, slot 1 is the top offset byte, slot 2 is the middle byte and slot 3 is the low byte. `ib_cfg`=0 and `ib_addr` = {mem_base[31:19], slot1[2:0], slot2, slot3}. Slot 0, slot1[7:3] and mem_base[18:0] have no effect.
- R5: Data bytes of consecutive writes in one sequence fill slots 0 to 7 in arrival order, whatever the split between writes.
- R6: `ib_req` rises only in the cycle after `wr_end` of a write with End set. While it waits, `ib_addr`, `ib_wdata` and `ib_we` stay unchanged until `ib_ack` or `ib_err` is sampled.
- R7: `smb_stretch` is 1 from the cycle after the final `wr_end` until a response is sampled. In the cycle after that response, it is 0 and `smb_ack_vld` pulses.
- R8: `ib_err` makes the final acknowledgement a NACK (`smb_nack`=1). It leaves the read holding register unchanged.
- R9: When a header's command (bit 0, 1 = write) differs from the command of the sequence in progress, that write is NACKed at `wr_end` and no request is made. The sequence is dropped, so the next write fills from slot 0.
- R10: A successful internal read stores `ib_rdata`. `rd_byte` then shows bits 7:0, and each `rd_next` pulse moves to the next byte, wrapping after the fourth.
- R11: `ib_we` equals the sequence command. For a write, `ib_wdata` = {slot7, slot6, slot5, slot4}.
- R12: Data bytes beyond slot 7 are discarded without changing any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | A slave write begins; the next byte is its header |
| wr_byte_vld | input | 1 | Strobe for `wr_byte` |
| wr_byte | input | 8 | Header or data byte of the current write |
| wr_end | input | 1 | Current write is complete and awaits acknowledgement |
| rd_next | input | 1 | Advance the read byte pointer |
| rd_byte | output | 8 | Selected byte of the read holding register |
| smb_ack_vld | output | 1 | One-cycle acknowledgement decision |
| smb_nack | output | 1 | With `smb_ack_vld`: 1 = NACK |
| smb_stretch | output | 1 | Hold the SMBus clock low |
| mem_base | input | 32 | Base register for memory accesses |
| ib_req | output | 1 | Internal request |
| ib_we | output | 1 | Internal request is a write |
| ib_cfg | output | 1 | Internal request targets configuration space |
| ib_addr | output | 32 | Internal address |
| ib_wdata | output | 32 | Internal write data |
| ib_ack | input | 1 | Internal access completed |
| ib_err | input | 1 | Internal access failed |
| ib_rdata | input | 32 | Internal read data, valid with `ib_ack` |

## Verification
A slot pointer left stale by an earlier write, or a command that was not cleared, shows up on `ib_addr` or `ib_wdata` in the first cycle `ib_req` is high. That is one cycle after the final `wr_end`. Stretch-release faults and NACK faults appear in the cycle after the bus response. A holding-register or byte-pointer fault appears on `rd_byte` in the same cycle as the acknowledgement pulse or one cycle after an `rd_next` pulse. The stimulus mixes split positions, failing responses, mismatched commands and a reset taken in the middle of a sequence.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ACCEPT = 2'd1,
        EV_LAUNCH = 2'd2,
        EV_REJECT = 2'd3
    } smbb_ev_e;

    localparam int HDR_END_BIT = 7;
    localparam int HDR_MEM_BIT = 6;
    localparam int HDR_WE_BIT  = 0;
endpackage

// File: rtl/smbb_collect.sv
module smbb_collect
    import smbb_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_start,
    input  logic                  wr_byte_vld,
    input  logic [7:0]            wr_byte,
    input  logic                  wr_end,
    output smbb_ev_e              ev,
    output logic                  ev_we,
    output logic                  ev_mem,
    output logic [NSLOT-1:0][7:0] slots
);
    localparam int SLOT_W = $clog2(NSLOT + 1);
    localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(NSLOT);

    typedef struct packed {
        logic                  act;
        logic                  we;
        logic                  mem;
        logic                  fin;
        logic                  hdr;
        logic                  mism;
        logic [SLOT_W-1:0]     ptr;
        logic [NSLOT-1:0][7:0] sl;
    } col_t;

    col_t s_d, s_q;
    smbb_ev_e ev_d;

    always_comb begin
        s_d  = s_q;
        ev_d = EV_NONE;
        if (wr_start) begin
            s_d.hdr = 1'b1;
            s_d.fin = 1'b0;
        end else if (wr_byte_vld) begin
            if (s_q.hdr) begin
                s_d.hdr = 1'b0;
                s_d.fin = wr_byte[HDR_END_BIT];
                if (s_q.act && (s_q.we != wr_byte[HDR_WE_BIT])) begin
                    s_d.mism = 1'b1;
                end else begin
                    s_d.act = 1'b1;
                    s_d.we  = wr_byte[HDR_WE_BIT];
                    s_d.mem = wr_byte[HDR_MEM_BIT];
                end
            end else if (s_q.ptr < SLOT_MAX) begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (s_q.ptr == SLOT_W'(i)) s_d.sl[i] = wr_byte;
                end
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end else if (wr_end) begin
            if (s_q.mism)     ev_d = EV_REJECT;
            else if (s_q.fin) ev_d = EV_LAUNCH;
            else              ev_d = EV_ACCEPT;
            if (s_q.mism || s_q.fin) s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ev     = ev_d;
    assign ev_we  = s_q.we;
    assign ev_mem = s_q.mem;
    assign slots  = s_q.sl;

    assert_ptr_bound_R12: assert property (@(posedge clk) disable iff (rst)
        s_q.ptr <= SLOT_MAX);

    assert_full_slots_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (s_q.ptr == SLOT_MAX && !s_q.hdr && wr_byte_vld && !wr_start) |=> $stable(s_q.sl));
endmodule

// File: rtl/smbb_xfer.sv
module smbb_xfer
    import smbb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WIN_BITS   = 19,
    parameter int REG_BITS   = 12,
    parameter int ADDR_BYTES = 4,
    parameter int NSLOT      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  smbb_ev_e              ev,
    input  logic                  ev_we,
    input  logic                  ev_mem,
    input  logic [NSLOT-1:0][7:0] slots,
    input  logic [ADDR_W-1:0]     mem_base,
    input  logic                  ib_ack,
    input  logic                  ib_err,
    output logic                  ib_req,
    output logic                  ib_we,
    output logic                  ib_cfg,
    output logic [ADDR_W-1:0]     ib_addr,
    output logic [DATA_W-1:0]     ib_wdata,
    output logic                  smb_ack_vld,
    output logic                  smb_nack,
    output logic                  smb_stretch,
    output logic                  cap_en
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int SL_HI  = 1;
    localparam int SL_MID = 2;
    localparam int SL_LO  = 3;

    typedef struct packed {
        logic              req;
        logic              we;
        logic              cfg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack_vld;
        logic              nack;
        logic              stretch;
    } xf_t;

    xf_t s_d, s_q;
    logic [ADDR_W-1:0] cfg_addr, mem_addr;
    logic [DATA_W-1:0] wdata_asm;
    logic [15:0]       reg_raw;
    logic [23:0]       off_raw;
    logic              unused_bits;

    always_comb begin
        reg_raw  = {slots[SL_LO], slots[SL_MID]};
        off_raw  = {slots[SL_HI], slots[SL_MID], slots[SL_LO]};
        cfg_addr = '0;
        cfg_addr[REG_BITS-1:0] = reg_raw[REG_BITS-1:0];
        mem_addr = mem_base;
        mem_addr[WIN_BITS-1:0] = off_raw[WIN_BITS-1:0];
        for (int b = 0; b < DATA_BYTES; b++) begin
            wdata_asm[b*8 +: 8] = slots[ADDR_BYTES + b];
        end
    end

    assign unused_bits = ^{slots[0], reg_raw[15:REG_BITS], off_raw[23:WIN_BITS]};

    always_comb begin
        s_d         = s_q;
        s_d.ack_vld = 1'b0;
        s_d.nack    = 1'b0;
        cap_en      = 1'b0;
        if (s_q.req) begin
            if (ib_ack || ib_err) begin
                s_d.req     = 1'b0;
                s_d.stretch = 1'b0;
                s_d.ack_vld = 1'b1;
                s_d.nack    = ib_err;
                cap_en      = !ib_err && !s_q.we;
            end
        end else begin
            unique case (ev)
                EV_ACCEPT: s_d.ack_vld = 1'b1;
                EV_REJECT: begin
                    s_d.ack_vld = 1'b1;
                    s_d.nack    = 1'b1;
                end
                EV_LAUNCH: begin
                    s_d.req     = 1'b1;
                    s_d.stretch = 1'b1;
                    s_d.we      = ev_we;
                    s_d.cfg     = !ev_mem;
                    s_d.addr    = ev_mem ? mem_addr : cfg_addr;
                    s_d.wdata   = ev_we ? wdata_asm : '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ib_req      = s_q.req;
    assign ib_we       = s_q.we;
    assign ib_cfg      = s_q.cfg;
    assign ib_addr     = s_q.addr;
    assign ib_wdata    = s_q.wdata;
    assign smb_ack_vld = s_q.ack_vld;
    assign smb_nack    = s_q.nack;
    assign smb_stretch = s_q.stretch;

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ib_req && !ib_ack && !ib_err) |=>
            (ib_req && $stable(ib_addr) && $stable(ib_wdata) && $stable(ib_we)));

    assert_req_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ib_req) |-> ($past(ev) == EV_LAUNCH));

    assert_stretch_release_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(smb_stretch) |-> (smb_ack_vld && ($past(ib_ack) || $past(ib_err))));

    assert_nack_with_ack_R8: assert property (@(posedge clk) disable iff (rst)
        smb_nack |-> smb_ack_vld);
endmodule

// File: rtl/smbb_rdhold.sv
module smbb_rdhold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              rd_next,
    output logic [7:0]        rd_byte
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int IDX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [IDX_W-1:0]  idx;
    } rh_t;

    rh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_en) begin
            s_d.hold = cap_data;
            s_d.idx  = '0;
        end else if (rd_next) begin
            if (s_q.idx == IDX_W'(DATA_BYTES - 1)) s_d.idx = '0;
            else                                   s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if (s_q.idx == IDX_W'(b)) rd_byte = s_q.hold[b*8 +: 8];
        end
    end

    assert_capture_lsb_R10: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (rd_byte == $past(cap_data[7:0])));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !rd_next) |=> $stable(rd_byte));
endmodule

// File: rtl/smbus_reg_bridge.sv
module smbus_reg_bridge
    import smbb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 19,
    parameter int REG_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic              wr_byte_vld,
    input  logic [7:0]        wr_byte,
    input  logic              wr_end,
    input  logic              rd_next,
    output logic [7:0]        rd_byte,
    output logic              smb_ack_vld,
    output logic              smb_nack,
    output logic              smb_stretch,
    input  logic [ADDR_W-1:0] mem_base,
    output logic              ib_req,
    output logic              ib_we,
    output logic              ib_cfg,
    output logic [ADDR_W-1:0] ib_addr,
    output logic [DATA_W-1:0] ib_wdata,
    input  logic              ib_ack,
    input  logic              ib_err,
    input  logic [DATA_W-1:0] ib_rdata
);
    localparam int ADDR_BYTES = 4;
    localparam int NSLOT      = ADDR_BYTES + DATA_W / 8;

    smbb_ev_e              ev;
    logic                  ev_we, ev_mem, cap_en;
    logic [NSLOT-1:0][7:0] slots;

    smbb_collect #(.NSLOT(NSLOT)) i_collect (
        .clk(clk), .rst(rst),
        .wr_start(wr_start), .wr_byte_vld(wr_byte_vld), .wr_byte(wr_byte), .wr_end(wr_end),
        .ev(ev), .ev_we(ev_we), .ev_mem(ev_mem), .slots(slots)
    );

    smbb_xfer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS),
        .REG_BITS(REG_BITS), .ADDR_BYTES(ADDR_BYTES), .NSLOT(NSLOT)
    ) i_xfer (
        .clk(clk), .rst(rst),
        .ev(ev), .ev_we(ev_we), .ev_mem(ev_mem), .slots(slots), .mem_base(mem_base),
        .ib_ack(ib_ack), .ib_err(ib_err),
        .ib_req(ib_req), .ib_we(ib_we), .ib_cfg(ib_cfg), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .smb_ack_vld(smb_ack_vld), .smb_nack(smb_nack), .smb_stretch(smb_stretch),
        .cap_en(cap_en)
    );

    smbb_rdhold #(.DATA_W(DATA_W)) i_rdhold (
        .clk(clk), .rst(rst),
        .cap_en(cap_en), .cap_data(ib_rdata), .rd_next(rd_next), .rd_byte(rd_byte)
    );
endmodule

// File: tb/test_smbus_reg_bridge.sv
module test_smbus_reg_bridge;
    logic        clk = 1'b0;
    logic        rst, wr_start, wr_byte_vld, wr_end, rd_next;
    logic [7:0]  wr_byte, rd_byte;
    logic        smb_ack_vld, smb_nack, smb_stretch;
    logic [31:0] mem_base, ib_addr, ib_wdata, ib_rdata;
    logic        ib_req, ib_we, ib_cfg, ib_ack, ib_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    smbus_reg_bridge i_smbus_reg_bridge (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_byte_vld(wr_byte_vld),
        .wr_byte(wr_byte), .wr_end(wr_end), .rd_next(rd_next), .rd_byte(rd_byte),
        .smb_ack_vld(smb_ack_vld), .smb_nack(smb_nack), .smb_stretch(smb_stretch),
        .mem_base(mem_base), .ib_req(ib_req), .ib_we(ib_we), .ib_cfg(ib_cfg),
        .ib_addr(ib_addr), .ib_wdata(ib_wdata), .ib_ack(ib_ack), .ib_err(ib_err),
        .ib_rdata(ib_rdata)
    );

    typedef struct packed {
        logic            mem;
        logic            we;
        logic [3:0]      split;
        logic [3:0]      nb;
        logic [7:0][7:0] bytes;
        logic [31:0]     exp_addr;
        logic            err;
        logic [31:0]     rdata;
        logic [3:0]      lat;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 4'd0, 4'd8, 64'h12345678_F5342211, 32'h0000_0534, 1'b0, 32'h0,         4'd2},
        '{1'b0, 1'b0, 4'd2, 4'd4, 64'h00000000_ABFF8899, 32'h0000_0BFF, 1'b0, 32'hCAFE_F00D, 4'd0},
        '{1'b1, 1'b0, 4'd1, 4'd4, 64'h00000000_EFBEFD77, 32'hA5AD_BEEF, 1'b0, 32'h0102_0304, 4'd5},
        '{1'b1, 1'b1, 4'd3, 4'd8, 64'h89ABCDEF_FFFF0700, 32'hA5AF_FFFF, 1'b0, 32'h0,         4'd1},
        '{1'b1, 1'b1, 4'd6, 4'd8, 64'hDEADBEEF_00000000, 32'hA5A8_0000, 1'b1, 32'h0,         4'd0},
        '{1'b0, 1'b0, 4'd0, 4'd4, 64'h00000000_10010000, 32'h0000_0001, 1'b1, 32'hFFFF_FFFF, 4'd3},
        '{1'b1, 1'b0, 4'd0, 4'd4, 64'h00000000_0100F8FF, 32'hA5A8_0001, 1'b0, 32'h89AB_CDEF, 4'd0},
        '{1'b0, 1'b1, 4'd0, 4'd8, 64'hA1B2C3D4_0534DDEE, 32'h0000_0534, 1'b0, 32'h0,         4'd2}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_write(input logic [7:0] hdr, input logic [15:0][7:0] b,
                              input int first, input int last);
        @(negedge clk) wr_start = 1'b1;
        @(negedge clk) begin
            wr_start    = 1'b0;
            wr_byte_vld = 1'b1;
            wr_byte     = hdr;
        end
        for (int i = first; i < last; i++) begin
            @(negedge clk) wr_byte = b[i];
        end
        @(negedge clk) begin
            wr_byte_vld = 1'b0;
            wr_end      = 1'b1;
        end
        @(negedge clk) wr_end = 1'b0;
    endtask

    task automatic respond(input logic err, input logic [31:0] data);
        ib_ack   = !err;
        ib_err   = err;
        ib_rdata = data;
        @(negedge clk);
        ib_ack = 1'b0;
        ib_err = 1'b0;
    endtask

    task automatic check_done(input string tag, input logic nack);
        check({tag, " ack pulse"},       {31'd0, smb_ack_vld}, 32'd1);
        check({tag, " nack"},            {31'd0, smb_nack},    {31'd0, nack});
        check({tag, " stretch released"},{31'd0, smb_stretch}, 32'd0);
        check({tag, " req dropped"},     {31'd0, ib_req},      32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] last_good;
        rst = 1'b1; wr_start = 0; wr_byte_vld = 0; wr_byte = 0; wr_end = 0; rd_next = 0;
        ib_ack = 0; ib_err = 0; ib_rdata = 0; mem_base = 32'hA5AC_1234;
        last_good = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_byte", {24'd0, rd_byte}, 32'd0);
        check("R1 outputs", {28'd0, smb_ack_vld, smb_nack, smb_stretch, ib_req}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            vec_t        cv;
            logic [7:0]  hdr;
            logic [31:0] exp_wd;
            cv = VECS[v];
            exp_wd = cv.bytes[7:4];
            hdr = {1'b0, cv.mem, 5'd0, cv.we};
            if (cv.split != 0) begin
                send_write(hdr, {64'd0, cv.bytes}, 0, int'(cv.split));
                check("R2 partial ack", {30'd0, smb_ack_vld, smb_nack}, 32'd2);
                check("R2 no request",  {31'd0, ib_req}, 32'd0);
            end
            hdr[7] = 1'b1;
            send_write(hdr, {64'd0, cv.bytes}, int'(cv.split), int'(cv.nb));
            check("R6 request issued", {31'd0, ib_req}, 32'd1);
            check("R7 stretch on",     {30'd0, smb_stretch, smb_ack_vld}, 32'd2);
            check(cv.mem ? "R4 R5 mem address" : "R3 R5 cfg address", ib_addr, cv.exp_addr);
            check("R3 R4 space select", {31'd0, ib_cfg}, {31'd0, !cv.mem});
            check("R11 direction", {31'd0, ib_we}, {31'd0, cv.we});
            if (cv.we) check("R11 write data", ib_wdata, exp_wd);
            for (int k = 0; k < int'(cv.lat); k++) begin
                @(negedge clk);
                check("R7 stretch held", {30'd0, smb_stretch, smb_ack_vld}, 32'd2);
                check("R6 address held", ib_addr, cv.exp_addr);
            end
            respond(cv.err, cv.rdata);
            check_done(cv.err ? "R8 error" : "R7 complete", cv.err);
            if (!cv.we) begin
                if (cv.err) begin
                    check("R8 hold unchanged", {24'd0, rd_byte}, {24'd0, last_good[7:0]});
                end else begin
                    last_good = cv.rdata;
                    for (int b = 0; b < 4; b++) begin
                        check("R10 read byte", {24'd0, rd_byte}, {24'd0, cv.rdata[b*8 +: 8]});
                        @(negedge clk) rd_next = 1'b1;
                        @(negedge clk) rd_next = 1'b0;
                    end
                    check("R10 wrap", {24'd0, rd_byte}, {24'd0, cv.rdata[7:0]});
                end
            end
        end

        // R9 command mismatch
        send_write(8'h41, {120'd0, 8'hAA}, 0, 1);
        check("R9 first write ok", {30'd0, smb_ack_vld, smb_nack}, 32'd2);
        send_write(8'hC0, {112'd0, 16'hBBCC}, 0, 2);
        check("R9 mismatch nack", {30'd0, smb_ack_vld, smb_nack}, 32'd3);
        check("R9 no request", {30'd0, ib_req, smb_stretch}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 still idle", {31'd0, ib_req}, 32'd0);
        send_write(8'hC0, {96'd0, 32'h3412_0000}, 0, 4);
        check("R9 fresh sequence address", ib_addr, 32'hA5A8_1234);
        respond(1'b0, 32'h55AA_55AA);
        check_done("R9 follow-up", 1'b0);
        check("R10 capture", {24'd0, rd_byte}, 32'h0000_00AA);

        // R12 bytes beyond slot 7
        send_write(8'hC1, {48'd0, 80'h8899_4433_2211_0302_0100}, 0, 10);
        check("R12 address", ib_addr, 32'hA5A9_0203);
        check("R12 data unchanged by extras", ib_wdata, 32'h4433_2211);
        respond(1'b0, 32'h0);
        check_done("R12 complete", 1'b0);

        // R1 reset in the middle of a sequence
        send_write(8'h41, {104'd0, 24'hCCBBAA}, 0, 3);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 hold cleared", {24'd0, rd_byte}, 32'd0);
        send_write(8'hC0, {96'd0, 32'h1000_0000}, 0, 4);
        check("R1 slots cleared request", {31'd0, ib_req}, 32'd1);
        check("R1 slots cleared address", ib_addr, 32'hA5A8_0010);
        respond(1'b0, 32'h0BAD_CAFE);
        check_done("R1 after reset", 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule